// File: doc/BRIEF.md
# Blitter DMA Slot Sequencer

This block sets the order in which a blitter claims memory bus slots. When a blit starts, it captures a 4-bit channel-enable mask, a fill-mode flag, a line-mode flag and a word count. It then steps through a repeating per-word pattern of slots. Each slot is a source fetch (A, B or C), a destination write (D), a plain idle, a bus-holding idle, or a true idle that leaves the bus to other masters. It does not generate addresses and does not process data. The surrounding blitter reads the slot code and does the matching transfer.

A slot that needs the bus moves forward only in a cycle where `bus_free` is high. Otherwise the sequencer stays on that slot. A true-idle slot moves forward every cycle, whatever the state of the bus. The destination result of a word is written in the next word's pattern. For this reason the D slot of the first word is a plain idle, and after the last word a two-slot flush (plain idle, then D write) writes out the held result.

The controller has four states. `ST_IDLE` waits for `start`. `ST_WORD` walks the per-word pattern. `ST_FLUSH` runs the two flush slots. `ST_DONE` lasts one cycle and raises `done`. The transitions are:
- start: `ST_IDLE` to `ST_WORD`.
- word wrap: `ST_WORD` to `ST_WORD` at the end of a word that is not the last.
- last word with D enabled and line mode off: `ST_WORD` to `ST_FLUSH`.
- last word otherwise: `ST_WORD` to `ST_DONE`.
- flush end: `ST_FLUSH` to `ST_DONE`.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `blt_slot_seq`

## Requirements
- R1: Slot codes are 0 plain idle, 1 A read, 2 B read, 3 C read, 4 D write, 5 true idle, 6 bus-holding idle. In `chan_mask`, bit 3 is A, bit 2 is B, bit 1 is C and bit 0 is D. With fill and line mode off, each word's pattern is built in this order:
  - first slot: A if enabled, else plain idle;
  - then B if enabled;
  - then C if enabled;
  - last slot: D if enabled, else bus-holding idle when A is enabled, else plain idle.
- R2: In the first word of a blit, the D slot is issued as a plain idle (code 0).
- R3: Codes 1 to 4 and 6 raise `bus_claim` in the cycle they advance. A plain idle needs `bus_free` but does not raise `bus_claim`.
- R4: Every slot except a true idle advances (`slot_adv`=1) only when `bus_free` is 1. While stalled, `slot_adv`, `bus_claim` and `slot_code` are all 0.
- R5: In fill mode, a normal pattern of 2 or 3 slots gets a true idle (code 5) inserted before its last slot. Patterns of 4 slots are unchanged. A true idle advances even when `bus_free` is 0 and never raises `bus_claim`.
- R6: Line mode overrides fill mode. Every word uses C read, true idle, D write, true idle. The D bit of the mask is ignored, and no flush follows.
- R7: Outside line mode with D enabled, the last word is followed by a plain idle and then a D write, both gated by `bus_free`.
- R8: `done` is high for exactly one cycle, in the cycle after the last slot advances. In the next cycle `busy` is 0.
- R9: `word_count` is captured at start. A count of 0 runs as one word.
- R10: `start` has no effect while `busy` is 1.
- R11: After reset, `busy`, `done`, `slot_adv` and `bus_claim` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a blit with the current configuration |
| chan_mask | input | 4 | Channel enables: bit3 A, bit2 B, bit1 C, bit0 D |
| fill_mode | input | 1 | Fill mode select |
| line_mode | input | 1 | Line mode select |
| word_count | input | WCW | Number of words in the blit |
| bus_free | input | 1 | The current bus slot is available to the blitter |
| slot_code | output | 3 | Code of the slot that advances this cycle, else 0 |
| slot_adv | output | 1 | A slot advanced this cycle |
| bus_claim | output | 1 | The advancing slot takes the bus |
| busy | output | 1 | A blit is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is a true-idle slot advancing while the bus is busy. It only shows up as the pattern stepping on in a cycle where every other slot would stall. To get there, the stimulus holds `bus_free` low, releases it for exactly one cycle so the plain idle ahead of the fill slot can pass, and then drops it again. In that cycle the sequencer must move to the true-idle slot without claiming the bus. A second stimulus pulses `start` partway through a run with a different mask. The emitted sequence must show that the captured configuration did not change.

// File: rtl/blt_seq_pkg.sv
package blt_seq_pkg;

    localparam logic [2:0] SLOT_NONE = 3'd0;
    localparam logic [2:0] SLOT_A    = 3'd1;
    localparam logic [2:0] SLOT_B    = 3'd2;
    localparam logic [2:0] SLOT_C    = 3'd3;
    localparam logic [2:0] SLOT_D    = 3'd4;
    localparam logic [2:0] SLOT_SKIP = 3'd5;
    localparam logic [2:0] SLOT_HOLD = 3'd6;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WORD  = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/blt_slot_pattern.sv
module blt_slot_pattern
    import blt_seq_pkg::*;
#(
    parameter int SLOTS = 4
) (
    input  logic [3:0] mask,
    input  logic       fill,
    input  logic       line,
    input  logic       first,
    input  logic [1:0] idx,
    output logic [2:0] code,
    output logic [2:0] len
);
    logic [2:0] seq [SLOTS];
    logic [2:0] tail;
    int         n;

    always_comb begin
        for (int i = 0; i < SLOTS; i++) seq[i] = SLOT_NONE;
        n = 0;
        if (line) begin
            seq[0] = SLOT_C;
            seq[1] = SLOT_SKIP;
            seq[2] = SLOT_D;
            seq[3] = SLOT_SKIP;
            n = 4;
            tail = SLOT_NONE;
        end else begin
            seq[0] = mask[3] ? SLOT_A : SLOT_NONE;
            n = 1;
            if (mask[2]) begin
                seq[n] = SLOT_B;
                n = n + 1;
            end
            if (mask[1]) begin
                seq[n] = SLOT_C;
                n = n + 1;
            end
            if (mask[0])      tail = first ? SLOT_NONE : SLOT_D;
            else if (mask[3]) tail = SLOT_HOLD;
            else              tail = SLOT_NONE;
            if (fill && n < 3) begin
                seq[n] = SLOT_SKIP;
                n = n + 1;
            end
            seq[n] = tail;
            n = n + 1;
        end
        len  = 3'(n);
        code = seq[idx];
    end
endmodule

// File: rtl/blt_word_counter.sv
module blt_word_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (load)    cnt <= (load_val == '0) ? W'(1) : load_val;
        else if (dec)     cnt <= cnt - W'(1);
    end

    assign last = (cnt == W'(1));

    p_load_nonzero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (cnt != '0));
endmodule

// File: rtl/blt_slot_seq.sv
module blt_slot_seq
    import blt_seq_pkg::*;
#(
    parameter int WCW = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    input  logic [3:0]     chan_mask,
    input  logic           fill_mode,
    input  logic           line_mode,
    input  logic [WCW-1:0] word_count,
    input  logic           bus_free,
    output logic [2:0]     slot_code,
    output logic           slot_adv,
    output logic           bus_claim,
    output logic           busy,
    output logic           done
);
    localparam int FLUSH_SLOTS = 2;

    seq_state_t state, state_nx;
    logic [3:0] mask_q;
    logic       fill_q, line_q, first_q;
    logic [1:0] idx_q;
    logic [2:0] pat_code, pat_len, cur_code;
    logic       adv, word_end, last_word, need_flush;

    blt_slot_pattern #(.SLOTS(4)) u_pattern (
        .mask  (mask_q),
        .fill  (fill_q),
        .line  (line_q),
        .first (first_q),
        .idx   (idx_q),
        .code  (pat_code),
        .len   (pat_len)
    );

    blt_word_counter #(.W(WCW)) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (state == ST_IDLE && start),
        .load_val (word_count),
        .dec      (state == ST_WORD && word_end && !last_word),
        .last     (last_word)
    );

    assign need_flush = !line_q && mask_q[0];

    always_comb begin
        unique case (state)
            ST_WORD:  cur_code = pat_code;
            ST_FLUSH: cur_code = (idx_q == 2'd0) ? SLOT_NONE : SLOT_D;
            default:  cur_code = SLOT_NONE;
        endcase
        adv = (state == ST_WORD || state == ST_FLUSH)
              && (cur_code == SLOT_SKIP || bus_free);
        word_end = adv && ({1'b0, idx_q} == pat_len - 3'd1);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_WORD;
            ST_WORD:  if (word_end && last_word)
                          state_nx = need_flush ? ST_FLUSH : ST_DONE;
            ST_FLUSH: if (adv && idx_q == 2'(FLUSH_SLOTS - 1)) state_nx = ST_DONE;
            ST_DONE:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            mask_q  <= '0;
            fill_q  <= 1'b0;
            line_q  <= 1'b0;
            first_q <= 1'b0;
            idx_q   <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                mask_q  <= chan_mask;
                fill_q  <= fill_mode;
                line_q  <= line_mode;
                first_q <= 1'b1;
                idx_q   <= '0;
            end else if (state == ST_WORD && adv) begin
                if (word_end) begin
                    idx_q   <= '0;
                    first_q <= 1'b0;
                end else begin
                    idx_q <= idx_q + 2'd1;
                end
            end else if (state == ST_FLUSH && adv) begin
                idx_q <= idx_q + 2'd1;
            end
        end
    end

    always_comb begin
        slot_adv  = adv;
        slot_code = adv ? cur_code : SLOT_NONE;
        bus_claim = adv && cur_code != SLOT_NONE && cur_code != SLOT_SKIP;
        busy      = (state != ST_IDLE);
        done      = (state == ST_DONE);
    end

    p_claim_needs_bus_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_free |-> !bus_claim);
    p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    p_skip_only_fill_line_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_adv && slot_code == SLOT_SKIP) |-> (fill_q || line_q));
    p_line_no_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (line_q && slot_adv) |-> (slot_code != SLOT_HOLD));
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);
endmodule

// File: tb/test_blt_slot_seq.sv
`timescale 1ns/1ps
module test_blt_slot_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [3:0] chan_mask = 4'h0;
    logic       fill_mode = 1'b0;
    logic       line_mode = 1'b0;
    logic [7:0] word_count = 8'd0;
    logic       bus_free = 1'b1;
    logic [2:0] slot_code;
    logic       slot_adv, bus_claim, busy, done;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    blt_slot_seq #(.WCW(8)) i_blt_slot_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .chan_mask(chan_mask),
        .fill_mode(fill_mode), .line_mode(line_mode), .word_count(word_count),
        .bus_free(bus_free), .slot_code(slot_code), .slot_adv(slot_adv),
        .bus_claim(bus_claim), .busy(busy), .done(done)
    );

    // mask[49:46] fill[45] line[44] words[43:40] nslots[39:36] codes[35:0], first slot in top octal digit
    localparam int NV = 9;
    localparam logic [49:0] VEC [NV] = '{
        {4'hF, 1'b0, 1'b0, 4'd2, 4'd10, 36'o123012340400},  // R1 R2 R7
        {4'h8, 1'b0, 1'b0, 4'd2, 4'd4,  36'o161600000000},  // R1 R3
        {4'h0, 1'b1, 1'b0, 4'd1, 4'd3,  36'o050000000000},  // R5
        {4'hC, 1'b1, 1'b0, 4'd2, 4'd8,  36'o125612560000},  // R5
        {4'h5, 1'b0, 1'b0, 4'd2, 4'd8,  36'o020024040000},  // R1 R2 R7
        {4'h0, 1'b1, 1'b1, 4'd2, 4'd8,  36'o354535450000},  // R6
        {4'h1, 1'b1, 1'b0, 4'd1, 4'd5,  36'o050040000000},  // R5 R7
        {4'hA, 1'b0, 1'b0, 4'd1, 4'd3,  36'o136000000000},  // R1
        {4'h7, 1'b1, 1'b0, 4'd1, 4'd6,  36'o023004000000}   // R5 R7
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic expect_slot(input logic [2:0] exp, input string req);
        bit claim_exp;
        claim_exp = (exp != 3'd0 && exp != 3'd5);
        check(slot_adv === 1'b1, {req, " adv"}, int'(slot_adv), 1);
        check(slot_code === exp, {req, " code"}, int'(slot_code), int'(exp));
        check(bus_claim === claim_exp, {req, " claim"}, int'(bus_claim), int'(claim_exp));
    endtask

    task automatic expect_stall(input string req);
        check(slot_adv === 1'b0 && bus_claim === 1'b0 && slot_code === 3'd0,
              req, int'(slot_adv), 0);
    endtask

    task automatic launch(input logic [3:0] m, input bit f, input bit l, input logic [7:0] w);
        @(negedge clk);
        chan_mask = m; fill_mode = f; line_mode = l; word_count = w; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic expect_end(input string req);
        check(done === 1'b1, {req, " done"}, int'(done), 1);
        @(negedge clk);
        check(done === 1'b0 && busy === 1'b0, {req, " release"}, int'(busy), 0);
    endtask

    initial begin
        #(200000 * 8);
        failures++;
        $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check(busy === 1'b0 && done === 1'b0 && slot_adv === 1'b0 && bus_claim === 1'b0,
              "R11 reset", int'(busy), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            launch(VEC[v][49:46], VEC[v][45], VEC[v][44], {4'd0, VEC[v][43:40]});
            for (int s = 0; s < int'(VEC[v][39:36]); s++) begin
                expect_slot(VEC[v][35 - 3*s -: 3], $sformatf("R1/R5/R6/R7 vec%0d slot%0d", v, s));
                @(negedge clk);
            end
            expect_end($sformatf("R8 vec%0d", v));
        end

        // R4 stall on busy bus, mask 8 one word
        bus_free = 1'b0;
        launch(4'h8, 1'b0, 1'b0, 8'd1);
        expect_stall("R4 stall a");
        @(negedge clk);
        expect_stall("R4 stall b");
        check(busy === 1'b1, "R4 busy held", int'(busy), 1);
        bus_free = 1'b1;
        #1;
        expect_slot(3'd1, "R4 resume A");
        @(negedge clk);
        expect_slot(3'd6, "R3 hold claims");
        @(negedge clk);
        expect_end("R8 after stall");

        // R5 true idle advances while bus busy
        bus_free = 1'b0;
        launch(4'h0, 1'b1, 1'b0, 8'd1);
        expect_stall("R3 plain idle needs bus");
        bus_free = 1'b1;
        #1;
        expect_slot(3'd0, "R3 plain idle no claim");
        @(negedge clk);
        bus_free = 1'b0;
        #1;
        expect_slot(3'd5, "R5 skip on busy bus");
        @(negedge clk);
        expect_stall("R5 following idle stalls");
        bus_free = 1'b1;
        #1;
        expect_slot(3'd0, "R5 final idle");
        @(negedge clk);
        expect_end("R8 fill");

        // R10 start ignored while busy
        launch(4'h8, 1'b0, 1'b0, 8'd2);
        chan_mask = 4'hF; word_count = 8'd5; start = 1'b1;
        #1;
        expect_slot(3'd1, "R10 slot0");
        @(negedge clk);
        start = 1'b0;
        expect_slot(3'd6, "R10 slot1");
        @(negedge clk);
        expect_slot(3'd1, "R10 slot2");
        @(negedge clk);
        expect_slot(3'd6, "R10 slot3");
        @(negedge clk);
        expect_end("R10 end");

        // R9 zero count runs one word
        launch(4'h8, 1'b0, 1'b0, 8'd0);
        expect_slot(3'd1, "R9 zero slot0");
        @(negedge clk);
        expect_slot(3'd6, "R9 zero slot1");
        @(negedge clk);
        expect_end("R9 zero end");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule